// File: doc/BRIEF.md
# Programmable Pulse Cycle Sequencer

This block is the timing engine of a pulse generator. It runs from a single clock whose period is the smallest time step. Each cycle, called a repetition interval, starts with a trigger-out strobe and places one or two output pulses inside the interval. The interval and the pulse delay are set as a 10-bit multiplier times a tick that one shared range code selects. The pulse width has its own 10-bit multiplier and its own range code, and that width range also sets how long the trigger-out strobe lasts.

Cycles can run in three ways. In free-run they repeat on their own. In edge mode each rising edge of an asynchronous trigger input starts one cycle. In gate mode cycles repeat for as long as that input is high. A master run bit enables all of this. Range codes that are out of range stop all activity. The trigger input is resynchronised before it is used. The pulse and trigger-out outputs are registered and move together, so every pulse offset holds relative to the rising edge of trigger-out.

Top module: `pulse_cycle_seq`

## Requirements
- R1: While rstN is low, and right after it is released, pulseOut, trigOut and running are all 0.
- R2: With run=1 and freeRun=1, a new cycle starts every priMult*4^prdRange clocks, and the trigger input has no effect on that period. A priMult of 0 counts as 1.
- R3: trigOut goes high at the start of every cycle and stays high for 4^widRange clocks.
- R4: With delayMode=0 and doubleMode=0, one pulse rises in the same clock as trigOut and lasts widMult*4^widRange clocks.
- R5: With delayMode=1 and doubleMode=0, one pulse rises dlyMult*4^prdRange clocks after trigOut rises. A dlyMult of 0 counts as 1.
- R6: With doubleMode=1, and whatever delayMode is, each cycle holds a primary pulse that starts with trigOut and a second pulse of the same width that starts at the delay offset.
- R7: When delay plus width reaches past the end of the interval, the pulse is cut off at the start of the next cycle.
- R8: With freeRun=0 and gateMode=0, a rising edge on trigIn starts exactly one cycle. Edges that arrive before that cycle's interval ends are ignored, even after its pulse has finished.
- R9: With freeRun=0 and gateMode=1, cycles repeat while trigIn is high. Once trigIn falls, the cycle in progress completes and no further cycle starts.
- R10: With run=0 no cycle starts. When run falls, running, pulseOut and trigOut are all 0 by the next clock.
- R11: A range code of 6 or 7 on prdRange or widRange blocks every cycle, so running stays 0 and no trigOut appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; one period is the smallest tick |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Master enable for pulse generation |
| freeRun | input | 1 | 1: cycles repeat on their own; 0: trigIn controls them |
| gateMode | input | 1 | With freeRun=0: 0 for edge-started cycles, 1 for gated repetition |
| delayMode | input | 1 | Place the single pulse at the delay offset |
| doubleMode | input | 1 | Primary plus delayed pulse; overrides delayMode |
| prdRange | input | 3 | Range code shared by interval and delay (tick 4^code clocks) |
| widRange | input | 3 | Range code for pulse width and trigger-out width |
| priMult | input | 10 | Interval multiplier |
| dlyMult | input | 10 | Delay multiplier |
| widMult | input | 10 | Width multiplier |
| trigIn | input | 1 | Asynchronous trigger or gate input |
| pulseOut | output | 1 | Generated pulse stream |
| trigOut | output | 1 | Start-of-cycle strobe |
| running | output | 1 | High while a cycle is in progress |

## Verification
The scoreboard measures every pulse by its offset from the last trigOut rise and by its length. It also measures the spacing between trigOut rises and the length of each strobe. Free-run is tried with single, delayed, double and overrun settings and at two range codes, which separates errors in the start position, in the width scaling and in the shared range shift. In free-run the trigger input toggles throughout, and any pull it had on timing would show as a spacing error. Edge mode sends a second edge inside the interval and a third edge after it, which separates lockout from plain edge counting. Gate mode drops the gate in the middle of a cycle, which shows whether the last cycle runs to its end. Run drops and illegal range codes show whether activity stops.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic {
    SEQ_IDLE   = 1'b0,
    SEQ_ACTIVE = 1'b1
  } seqState_t;

  typedef struct packed {
    logic start;   // clear the elapsed counter and open a new cycle
    logic count;   // advance the elapsed counter
    logic live;    // a cycle is open and enabled this clock
  } seqStrobe_t;

endpackage

// File: rtl/pcs_control.sv
module pcs_control
  import pcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       freeRun,
  input  logic       gateMode,
  input  logic       rangesOk,
  input  logic       trigIn,
  input  logic       lastTick,
  output seqStrobe_t strb,
  output logic       cycleOn
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevGate;
  logic                   gateHi;
  logic                   rise;
  logic                   enable;
  logic                   wantNew;
  logic                   wantMore;
  logic                   startNow;
  seqState_t              state;
  seqState_t              nextState;

  // trigger resynchroniser followed by a rising-edge detector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= '0;
      prevGate <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], trigIn};
      prevGate <= syncQ[SYNC_STAGES-1];
    end
  end

  assign gateHi = syncQ[SYNC_STAGES-1];
  assign rise   = gateHi & ~prevGate;

  always_comb begin
    enable    = run & rangesOk;
    wantNew   = freeRun | (gateMode ? gateHi : rise);
    wantMore  = freeRun | (gateMode & gateHi);
    startNow  = 1'b0;
    nextState = state;
    case (state)
      SEQ_IDLE: begin
        if (enable && wantNew) begin
          startNow  = 1'b1;
          nextState = SEQ_ACTIVE;
        end
      end
      SEQ_ACTIVE: begin
        if (!enable) begin
          nextState = SEQ_IDLE;
        end else if (lastTick) begin
          if (wantMore) startNow = 1'b1;
          else          nextState = SEQ_IDLE;
        end
      end
      default: nextState = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= nextState;
  end

  assign cycleOn    = (state == SEQ_ACTIVE);
  assign strb.start = startNow;
  assign strb.live  = cycleOn & enable;
  assign strb.count = cycleOn & enable & ~lastTick;

endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int MULT_W      = 10,
  parameter int RANGE_W     = 3,
  parameter int NUM_RANGES  = 6,
  parameter int RANGE_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  logic               delayMode,
  input  logic               doubleMode,
  input  logic [RANGE_W-1:0] prdRange,
  input  logic [RANGE_W-1:0] widRange,
  input  logic [MULT_W-1:0]  priMult,
  input  logic [MULT_W-1:0]  dlyMult,
  input  logic [MULT_W-1:0]  widMult,
  output logic               lastTick,
  output logic               pulseOut,
  output logic               trigOut
);

  localparam int CNT_W = MULT_W + RANGE_SHIFT * (NUM_RANGES - 1);

  logic [CNT_W-1:0] elapsed;
  logic [MULT_W-1:0] priEff;
  logic [MULT_W-1:0] dlyEff;
  logic [CNT_W-1:0] priClk;
  logic [CNT_W-1:0] dlyClk;
  logic [CNT_W-1:0] widClk;
  logic [CNT_W-1:0] trgClk;
  logic [CNT_W:0]   secEnd;
  logic             primaryOn;
  logic             secondOn;
  logic             trigOn;

  // multipliers of zero are promoted to one
  assign priEff = (priMult == '0) ? MULT_W'(1) : priMult;
  assign dlyEff = (dlyMult == '0) ? MULT_W'(1) : dlyMult;

  // each range step multiplies the tick by 2^RANGE_SHIFT
  assign priClk = CNT_W'(priEff)  << (RANGE_SHIFT * prdRange);
  assign dlyClk = CNT_W'(dlyEff)  << (RANGE_SHIFT * prdRange);
  assign widClk = CNT_W'(widMult) << (RANGE_SHIFT * widRange);
  assign trgClk = CNT_W'(1)       << (RANGE_SHIFT * widRange);
  assign secEnd = {1'b0, dlyClk} + {1'b0, widClk};

  assign lastTick  = (elapsed == priClk - CNT_W'(1));
  assign primaryOn = (doubleMode | ~delayMode) & (elapsed < widClk);
  assign secondOn  = (doubleMode | delayMode) & (elapsed >= dlyClk)
                   & ({1'b0, elapsed} < secEnd);
  assign trigOn    = (elapsed < trgClk);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      elapsed <= '0;
    end else if (strb.start) begin
      elapsed <= '0;
    end else if (strb.count) begin
      elapsed <= elapsed + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseOut <= 1'b0;
      trigOut  <= 1'b0;
    end else begin
      pulseOut <= strb.live & (primaryOn | secondOn);
      trigOut  <= strb.live & trigOn;
    end
  end

endmodule

// File: rtl/pulse_cycle_seq.sv
module pulse_cycle_seq
  import pcs_pkg::*;
#(
  parameter int MULT_W      = 10,
  parameter int RANGE_W     = 3,
  parameter int NUM_RANGES  = 6,
  parameter int RANGE_SHIFT = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               run,
  input  logic               freeRun,
  input  logic               gateMode,
  input  logic               delayMode,
  input  logic               doubleMode,
  input  logic [RANGE_W-1:0] prdRange,
  input  logic [RANGE_W-1:0] widRange,
  input  logic [MULT_W-1:0]  priMult,
  input  logic [MULT_W-1:0]  dlyMult,
  input  logic [MULT_W-1:0]  widMult,
  input  logic               trigIn,
  output logic               pulseOut,
  output logic               trigOut,
  output logic               running
);

  seqStrobe_t strb;
  logic       lastTick;
  logic       rangesOk;

  assign rangesOk = (32'(prdRange) < NUM_RANGES) && (32'(widRange) < NUM_RANGES);

  pcs_control #(.SYNC_STAGES(SYNC_STAGES)) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .run      (run),
    .freeRun  (freeRun),
    .gateMode (gateMode),
    .rangesOk (rangesOk),
    .trigIn   (trigIn),
    .lastTick (lastTick),
    .strb     (strb),
    .cycleOn  (running)
  );

  pcs_datapath #(
    .MULT_W      (MULT_W),
    .RANGE_W     (RANGE_W),
    .NUM_RANGES  (NUM_RANGES),
    .RANGE_SHIFT (RANGE_SHIFT)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .delayMode  (delayMode),
    .doubleMode (doubleMode),
    .prdRange   (prdRange),
    .widRange   (widRange),
    .priMult    (priMult),
    .dlyMult    (dlyMult),
    .widMult    (widMult),
    .lastTick   (lastTick),
    .pulseOut   (pulseOut),
    .trigOut    (trigOut)
  );

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int RANGE_W    = 3,
  parameter int NUM_RANGES = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               run,
  input logic               freeRun,
  input logic [RANGE_W-1:0] prdRange,
  input logic [RANGE_W-1:0] widRange,
  input logic               pulseOut,
  input logic               trigOut,
  input logic               running
);

  logic codesOk;
  assign codesOk = (32'(prdRange) < NUM_RANGES) && (32'(widRange) < NUM_RANGES);

  // R10
  run_low_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (!pulseOut && !trigOut && !running));

  // R11
  bad_range_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !codesOk |=> !running);

  // R2
  free_run_keeps_going_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && freeRun && codesOk && running) |=> running);

  // R4
  output_inside_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOut || trigOut) |-> $past(running));

  // R3
  strobe_rise_in_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigOut) |-> $past(running));

endmodule

bind pulse_cycle_seq pcs_checker #(.RANGE_W(RANGE_W), .NUM_RANGES(NUM_RANGES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .run      (run),
  .freeRun  (freeRun),
  .prdRange (prdRange),
  .widRange (widRange),
  .pulseOut (pulseOut),
  .trigOut  (trigOut),
  .running  (running)
);

// File: tb/pulse_cycle_seq_bench.sv
module pulse_cycle_seq_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       run = 1'b0;
  logic       freeRun = 1'b0;
  logic       gateMode = 1'b0;
  logic       delayMode = 1'b0;
  logic       doubleMode = 1'b0;
  logic [2:0] prdRange = 3'd0;
  logic [2:0] widRange = 3'd0;
  logic [9:0] priMult = 10'd10;
  logic [9:0] dlyMult = 10'd1;
  logic [9:0] widMult = 10'd1;
  logic       trigIn = 1'b0;
  logic       pulseOut;
  logic       trigOut;
  logic       running;

  always #2 clk = ~clk;

  pulse_cycle_seq u_pulse_cycle_seq (
    .clk(clk), .rstN(rstN), .run(run), .freeRun(freeRun), .gateMode(gateMode),
    .delayMode(delayMode), .doubleMode(doubleMode), .prdRange(prdRange),
    .widRange(widRange), .priMult(priMult), .dlyMult(dlyMult), .widMult(widMult),
    .trigIn(trigIn), .pulseOut(pulseOut), .trigOut(trigOut), .running(running)
  );

  int    errs = 0;
  int    total = 0;
  int    expOff[$];
  int    expLen[$];
  string curReq = "R4";
  bit    chkPulses = 1'b0;
  int    expPeriod = 0;
  int    expTrigW = 0;
  int    now = 0;
  int    tRise = 0;
  int    pOff = 0;
  int    pRise = 0;
  int    lastRise = -1;
  int    riseCnt = 0;
  bit    prevT = 1'b0;
  bit    prevP = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int scl(input int m, input int r);
    return ((m == 0) ? 1 : m) * (4 ** r);
  endfunction

  // monitor: measures strobes and pulses, pops the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      now++;
      if (trigOut && !prevT) begin
        if (lastRise >= 0 && expPeriod > 0)
          chk(now - lastRise == expPeriod, "R2", "cycle spacing", now - lastRise, expPeriod);
        lastRise = now;
        tRise = now;
        riseCnt++;
      end
      if (!trigOut && prevT && expTrigW > 0)
        chk(now - tRise == expTrigW, "R3", "strobe width", now - tRise, expTrigW);
      if (pulseOut && !prevP) begin
        pRise = now;
        pOff = now - tRise;
      end
      if (!pulseOut && prevP && chkPulses) begin
        if (expOff.size() == 0) begin
          chk(1'b0, curReq, "unexpected pulse offset", pOff, -1);
        end else begin
          int eo;
          int el;
          eo = expOff.pop_front();
          el = expLen.pop_front();
          chk(pOff == eo, curReq, "pulse offset", pOff, eo);
          chk(now - pRise == el, curReq, "pulse length", now - pRise, el);
        end
      end
      prevT = trigOut;
      prevP = pulseOut;
    end
  end

  task automatic push(input int off, input int len);
    expOff.push_back(off);
    expLen.push_back(len);
  endtask

  task automatic waitRises(input int n, input bit wiggle);
    int base;
    base = riseCnt;
    while (riseCnt < base + n) begin
      @(negedge clk);
      if (wiggle) trigIn = ~trigIn;
    end
  endtask

  task automatic setup(input bit fr, input bit gm, input bit dm, input bit db,
                       input int pr, input int wr, input int pm, input int dl,
                       input int wm);
    freeRun = fr; gateMode = gm; delayMode = dm; doubleMode = db;
    prdRange = 3'(pr); widRange = 3'(wr);
    priMult = 10'(pm); dlyMult = 10'(dl); widMult = 10'(wm);
    lastRise = -1;
  endtask

  // free-run scenario: k cycles, run dropped w clocks after the last strobe
  task automatic freeScenario(input string req, input int k, input int w,
                              input bit wiggle);
    curReq = req;
    chkPulses = 1'b1;
    expPeriod = scl(int'(priMult), int'(prdRange));
    expTrigW = 4 ** int'(widRange);
    @(negedge clk);
    run = 1'b1;
    waitRises(k, wiggle);
    repeat (w) @(negedge clk);
    run = 1'b0;
    trigIn = 1'b0;
    repeat (30) @(negedge clk);
    chk(expOff.size() == 0, req, "missing pulses", expOff.size(), 0);
    chkPulses = 1'b0;
    expOff.delete();
    expLen.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    int base;
    // R1 reset state
    repeat (4) @(negedge clk);
    chk({pulseOut, trigOut, running} == 3'b000, "R1", "outputs in reset",
        int'({pulseOut, trigOut, running}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({pulseOut, trigOut, running} == 3'b000, "R1", "outputs after reset",
        int'({pulseOut, trigOut, running}), 0);

    // R4 single, free-run, trigger input toggling (R2)
    setup(1, 0, 0, 0, 0, 0, 10, 1, 3);
    for (int i = 0; i < 3; i++) push(0, scl(3, 0));
    freeScenario("R4", 3, 5, 1'b1);

    // R5 delayed pulse
    setup(1, 0, 1, 0, 0, 0, 20, 5, 4);
    for (int i = 0; i < 3; i++) push(scl(5, 0), scl(4, 0));
    freeScenario("R5", 3, 12, 1'b0);

    // R6 double pulse with delayed also set
    setup(1, 0, 1, 1, 0, 0, 20, 8, 3);
    for (int i = 0; i < 3; i++) begin
      push(0, 3);
      push(scl(8, 0), scl(3, 0));
    end
    freeScenario("R6", 3, 14, 1'b0);

    // R5 and R3 at range code 1 on both fields
    setup(1, 0, 1, 0, 1, 1, 5, 2, 2);
    for (int i = 0; i < 3; i++) push(scl(2, 1), scl(2, 1));
    freeScenario("R5", 3, 18, 1'b0);

    // R7 overrun cut at cycle end
    setup(1, 0, 1, 0, 0, 0, 10, 7, 6);
    for (int i = 0; i < 2; i++) push(7, 10 - 7);
    freeScenario("R7", 3, 2, 1'b0);

    // R5 zero delay multiplier behaves as one
    setup(1, 0, 1, 0, 0, 0, 10, 0, 2);
    for (int i = 0; i < 3; i++) push(1, 2);
    freeScenario("R5", 3, 5, 1'b0);

    // R8 edge mode with lockout
    setup(0, 0, 0, 0, 0, 0, 30, 1, 2);
    expPeriod = 0; expTrigW = 1; curReq = "R8"; chkPulses = 1'b1;
    push(0, 2); push(0, 2);
    base = riseCnt;
    run = 1'b1;
    repeat (5) @(negedge clk);
    trigIn = 1'b1; repeat (3) @(negedge clk); trigIn = 1'b0;
    repeat (12) @(negedge clk);
    trigIn = 1'b1; repeat (3) @(negedge clk); trigIn = 1'b0;
    repeat (60) @(negedge clk);
    chk(riseCnt == base + 1, "R8", "cycles after locked-out edge", riseCnt - base, 1);
    trigIn = 1'b1; repeat (3) @(negedge clk); trigIn = 1'b0;
    repeat (40) @(negedge clk);
    chk(riseCnt == base + 2, "R8", "cycles after late edge", riseCnt - base, 2);
    chk(expOff.size() == 0, "R8", "missing pulses", expOff.size(), 0);
    run = 1'b0; chkPulses = 1'b0;
    repeat (5) @(negedge clk);

    // R9 gated repetition, gate falls mid-cycle
    setup(0, 1, 0, 0, 0, 0, 10, 1, 2);
    expPeriod = 10; expTrigW = 1; curReq = "R9"; chkPulses = 1'b1;
    for (int i = 0; i < 3; i++) push(0, 2);
    base = riseCnt;
    run = 1'b1;
    trigIn = 1'b1;
    waitRises(3, 1'b0);
    repeat (4) @(negedge clk);
    trigIn = 1'b0;
    repeat (3) @(negedge clk);
    chk(running == 1'b1, "R9", "cycle completes after gate falls", int'(running), 1);
    repeat (30) @(negedge clk);
    chk(riseCnt == base + 3, "R9", "cycles in gate window", riseCnt - base, 3);
    chk(running == 1'b0, "R9", "stopped after gate", int'(running), 0);
    chk(expOff.size() == 0, "R9", "missing pulses", expOff.size(), 0);
    run = 1'b0; chkPulses = 1'b0;
    repeat (5) @(negedge clk);

    // R10 run drop mid-pulse, then run held low
    setup(1, 0, 0, 0, 0, 0, 10, 1, 8);
    expPeriod = 0; expTrigW = 0;
    run = 1'b1;
    waitRises(1, 1'b0);
    repeat (3) @(negedge clk);
    chk(pulseOut == 1'b1, "R10", "pulse high before drop", int'(pulseOut), 1);
    run = 1'b0;
    repeat (2) @(negedge clk);
    chk({pulseOut, trigOut, running} == 3'b000, "R10", "outputs after run drop",
        int'({pulseOut, trigOut, running}), 0);
    base = riseCnt;
    repeat (40) @(negedge clk);
    chk(riseCnt == base, "R10", "cycles with run low", riseCnt - base, 0);

    // R11 illegal range codes
    setup(1, 0, 0, 0, 6, 0, 10, 1, 2);
    base = riseCnt;
    run = 1'b1;
    repeat (40) @(negedge clk);
    chk(riseCnt == base && !running, "R11", "cycles with prdRange 6", riseCnt - base, 0);
    run = 1'b0;
    setup(1, 0, 0, 0, 0, 7, 10, 1, 2);
    run = 1'b1;
    repeat (40) @(negedge clk);
    chk(riseCnt == base && !running, "R11", "cycles with widRange 7", riseCnt - base, 0);
    run = 1'b0;
    repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

endmodule